// File: doc/BRIEF.md
# Programmable Serial CRC Engine

This block computes a cyclic redundancy check over a serial bit stream, one bit per accepted strobe. The polynomial, the initial value and the check length (none, 8, 16 or 24 bits) are programmable. A start strobe samples the configuration and opens a packet. The stream then passes through an address phase, a body phase and a CRC phase, and a phase tag marks each bit with the phase it belongs to. An option leaves the address phase out of the calculation.

The block works in one of two directions. In transmit direction, the engine drives the computed remainder serially during the CRC phase, most significant bit first. In receive direction, it compares each arriving CRC bit against the remainder. When the last bit has arrived, it raises exactly one of two result pulses, updates a sticky status bit and stores the received CRC bits in a capture register. The capture register is written whether or not the check passed. The computed remainder itself is never visible at the ports.

Top module: `crc_serial_unit`

## Requirements
- R1: The length code selects the check width: 0 means no CRC, and 1, 2 and 3 select 8, 16 and 24 bits. With code 0, `crcBitOut` stays 0, no result pulse occurs, and status and capture keep their values.
- R2: Bit k of `cfgPoly` is the coefficient of x^k. Bit 0 is ignored and always treated as 1, so 0x18C and 0x18D give the same result for an 8-bit check.
- R3: On a start strobe, the remainder register is loaded with `cfgInit`, truncated to the selected width. A packet with no address or body bits therefore sends out that truncated initial value.
- R4: Each accepted bit of the address or body phase updates the remainder as follows. The feedback bit is the remainder's top bit XOR the input bit. The remainder shifts left by one, and the polynomial is XORed in when the feedback bit is 1.
- R5: When skip-address is sampled as 1, bits tagged with the address phase leave the remainder unchanged.
- R6: In transmit direction, during the CRC phase, `crcBitOut` shows the top bit of the remainder. Each accepted CRC-phase bit shifts the remainder left, so the check leaves the block most significant byte first and most significant bit first.
- R7: In receive direction, the clock cycle after the last CRC bit is accepted carries exactly one one-cycle pulse. The pulse is `crcOkPulse` if every received bit matched and `crcErrPulse` otherwise. Transmit packets never pulse.
- R8: `crcStatus` is 0 after reset. On each received result it becomes 1 for a pass or 0 for a failure, and it holds that value through later packets until the next received result.
- R9: At the result, `rxCrcCapture` holds the received CRC bits right-aligned, with the first received bit as the most significant bit and the upper bits zero. It is written whether or not the check passed.
- R10: The length, polynomial, initial value, skip flag and direction are sampled only on the start strobe. Changes made during a packet take effect from the next packet.
- R11: The start strobe has priority over address and body bits, and a data bit in the start cycle is dropped. A final CRC bit in the same cycle as a start still completes the old packet's result and capture while the new packet opens.
- R12: Once the selected number of CRC bits has been accepted, further CRC-phase bits are ignored: there is no output bit, no pulse and no capture change. Bits without `bitValid` change nothing. The phase tag is encoded as 0 for address, 1 for body, 2 for CRC and 3 for no phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgPoly | input | 24 | Polynomial coefficients, bit k for x^k |
| cfgInit | input | 24 | Initial remainder value |
| cfgLen | input | 2 | Length code: 0 none, 1/2/3 bytes |
| cfgSkipAddr | input | 1 | 1 leaves address-phase bits out of the calculation |
| cfgRxMode | input | 1 | 1 receive direction, 0 transmit direction |
| startStb | input | 1 | Opens a packet and samples the configuration |
| bitValid | input | 1 | Qualifies one serial bit |
| bitPhase | input | 2 | Phase tag of the current bit (0 addr, 1 body, 2 CRC, 3 none) |
| dataIn | input | 1 | Serial data bit |
| crcBitOut | output | 1 | Serial CRC bit in transmit direction |
| crcOkPulse | output | 1 | One-cycle pulse for a passed received check |
| crcErrPulse | output | 1 | One-cycle pulse for a failed received check |
| crcStatus | output | 1 | Sticky result of the last received check |
| rxCrcCapture | output | 24 | CRC bits of the last received packet |

## Verification
The two events that can share a cycle are the final CRC bit of a received packet and the start strobe of the next packet. The bench provokes this by raising the start strobe with new settings on the edge that accepts the last CRC bit. It then judges the old packet by its pulse, status and capture in the following cycle, and judges the new packet by its own correct result. Many random packets also open with a stray body bit beside the start strobe, which must be dropped. All packets scramble the configuration inputs right after starting.

// File: rtl/crc_pkg.sv
package crc_pkg;

  typedef enum logic [1:0] {
    PhAddr = 2'd0,
    PhBody = 2'd1,
    PhCrc  = 2'd2,
    PhNone = 2'd3
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // open a packet, load init
    logic absorb;  // fold one data bit into the remainder
    logic shift;   // CRC-phase bit: plain shift of the remainder
    logic rxBit;   // CRC-phase bit in receive direction
    logic finish;  // last CRC bit in receive direction
  } crc_ctl_t;

endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_pkg::*;
#(
  parameter int unsigned MaxBytes = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               startStb,
  input  logic                               bitValid,
  input  logic [1:0]                         bitPhase,
  input  logic                               cfgRxMode,
  input  logic [$clog2(MaxBytes+1)-1:0]      cfgLen,
  input  logic                               cfgSkipAddr,
  input  logic                               cmpFail,
  output crc_ctl_t                           ctl,
  output logic [$clog2(MaxBytes+1)-1:0]      lenQ,
  output logic [$clog2(MaxBytes+1)-1:0]      lenNext,
  output logic                               crcOutEn,
  output logic                               okPulse,
  output logic                               errPulse,
  output logic                               statusQ
);

  localparam int unsigned CrcW = 8 * MaxBytes;
  localparam int unsigned LenW = $clog2(MaxBytes + 1);
  localparam int unsigned CntW = $clog2(CrcW + 1);

  logic            skipQ;
  logic            rxQ;
  logic            doneQ;
  logic [CntW-1:0] bitCnt;
  logic [CntW-1:0] activeW;
  logic            crcOn;
  logic            inCrc;
  logic            lastBit;
  phase_e          ph;

  assign ph      = phase_e'(bitPhase);
  assign lenNext = (cfgLen > LenW'(MaxBytes)) ? LenW'(MaxBytes) : cfgLen;
  assign activeW = CntW'(lenQ) << 3;
  assign crcOn   = (lenQ != '0);
  assign inCrc   = (ph == PhCrc) && crcOn && !doneQ;
  assign lastBit = (bitCnt == activeW - CntW'(1));
  assign crcOutEn = inCrc && !rxQ;

  always_comb begin
    ctl        = '0;
    ctl.load   = startStb;
    ctl.absorb = bitValid && !startStb && crcOn &&
                 ((ph == PhBody) || ((ph == PhAddr) && !skipQ));
    ctl.shift  = bitValid && inCrc;
    ctl.rxBit  = bitValid && inCrc && rxQ;
    ctl.finish = bitValid && inCrc && rxQ && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ   <= '0;
      skipQ  <= 1'b0;
      rxQ    <= 1'b0;
      doneQ  <= 1'b0;
      bitCnt <= '0;
    end else if (startStb) begin
      lenQ   <= lenNext;
      skipQ  <= cfgSkipAddr;
      rxQ    <= cfgRxMode;
      doneQ  <= 1'b0;
      bitCnt <= '0;
    end else if (ctl.shift) begin
      bitCnt <= bitCnt + CntW'(1);
      if (lastBit) doneQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      okPulse  <= 1'b0;
      errPulse <= 1'b0;
      statusQ  <= 1'b0;
    end else begin
      okPulse  <= ctl.finish && !cmpFail;
      errPulse <= ctl.finish && cmpFail;
      if (ctl.finish) statusQ <= !cmpFail;
    end
  end

  // R7: never both results at once
  p_one_result_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(okPulse && errPulse));

  // R7: results only follow a receive-direction packet
  p_rx_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (okPulse || errPulse) |-> $past(rxQ));

  // R8: status agrees with the pulse that set it
  p_status_ok_r8: assert property (@(posedge clk) disable iff (!rstN)
    okPulse |-> statusQ);
  p_status_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !statusQ);

  // R12: bit counter never passes the active width
  p_cnt_bound_r12: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= activeW);

  // R1: a disabled check never produces a result
  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (lenQ == '0) |=> !(okPulse || errPulse));

endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_pkg::*;
#(
  parameter int unsigned MaxBytes = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  crc_ctl_t                           ctl,
  input  logic [8*MaxBytes-1:0]              cfgPoly,
  input  logic [8*MaxBytes-1:0]              cfgInit,
  input  logic [$clog2(MaxBytes+1)-1:0]      lenQ,
  input  logic [$clog2(MaxBytes+1)-1:0]      lenNext,
  input  logic                               crcOutEn,
  input  logic                               dataIn,
  output logic                               crcBitOut,
  output logic                               cmpFail,
  output logic [8*MaxBytes-1:0]              rxCapture
);

  localparam int unsigned CrcW = 8 * MaxBytes;

  logic [CrcW-1:0] polyQ;
  logic [CrcW-1:0] crcQ;
  logic [CrcW-1:0] rxShiftQ;
  logic [CrcW-1:0] captQ;
  logic            errAccQ;

  logic [CrcW-1:0] absorbVec [0:MaxBytes];
  logic [CrcW-1:0] shiftVec  [0:MaxBytes];
  logic [CrcW-1:0] initVec   [0:MaxBytes];
  logic [CrcW-1:0] maskVec   [0:MaxBytes];
  logic            msbVec    [0:MaxBytes];

  // One remainder variant per selectable width
  for (genvar g = 0; g <= MaxBytes; g++) begin : g_len
    if (g == 0) begin : g_off
      assign absorbVec[g] = '0;
      assign shiftVec[g]  = '0;
      assign initVec[g]   = '0;
      assign maskVec[g]   = '0;
      assign msbVec[g]    = 1'b0;
    end else begin : g_on
      localparam int unsigned W = 8 * g;
      localparam logic [CrcW:0] MFull = ((CrcW+1)'(1) << W) - (CrcW+1)'(1);
      logic fb;
      assign fb           = crcQ[W-1] ^ dataIn;
      assign absorbVec[g] = CrcW'({crcQ[W-2:0], 1'b0} ^ (fb ? polyQ[W-1:0] : W'(0)));
      assign shiftVec[g]  = CrcW'({crcQ[W-2:0], 1'b0});
      assign initVec[g]   = CrcW'(cfgInit[W-1:0]);
      assign maskVec[g]   = MFull[CrcW-1:0];
      assign msbVec[g]    = crcQ[W-1];
    end
  end

  logic            crcMsb;
  logic [CrcW-1:0] curMask;
  assign crcMsb    = msbVec[lenQ];
  assign curMask   = maskVec[lenQ];
  assign cmpFail   = errAccQ | (dataIn ^ crcMsb);
  assign crcBitOut = crcOutEn & crcMsb;
  assign rxCapture = captQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polyQ <= '0;
      crcQ  <= '0;
    end else if (ctl.load) begin
      polyQ <= cfgPoly | CrcW'(1);
      crcQ  <= initVec[lenNext];
    end else if (ctl.absorb) begin
      crcQ  <= absorbVec[lenQ];
    end else if (ctl.shift) begin
      crcQ  <= shiftVec[lenQ];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errAccQ  <= 1'b0;
      rxShiftQ <= '0;
    end else if (ctl.load) begin
      errAccQ  <= 1'b0;
      rxShiftQ <= '0;
    end else if (ctl.rxBit) begin
      errAccQ  <= cmpFail;
      rxShiftQ <= {rxShiftQ[CrcW-2:0], dataIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) captQ <= '0;
    else if (ctl.finish) captQ <= {rxShiftQ[CrcW-2:0], dataIn};
  end

  // R12: no strobe, no change of the remainder
  p_crc_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.absorb && !ctl.shift) |=> $stable(crcQ));

  // R9: capture never carries bits above the active width
  p_capt_width_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> ((captQ & ~$past(curMask)) == '0));

  // R6: no serial output while the check is disabled
  p_out_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lenQ == '0) |-> !crcBitOut);

endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit
  import crc_pkg::*;
#(
  parameter int unsigned MaxBytes = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [8*MaxBytes-1:0]         cfgPoly,
  input  logic [8*MaxBytes-1:0]         cfgInit,
  input  logic [$clog2(MaxBytes+1)-1:0] cfgLen,
  input  logic                          cfgSkipAddr,
  input  logic                          cfgRxMode,
  input  logic                          startStb,
  input  logic                          bitValid,
  input  logic [1:0]                    bitPhase,
  input  logic                          dataIn,
  output logic                          crcBitOut,
  output logic                          crcOkPulse,
  output logic                          crcErrPulse,
  output logic                          crcStatus,
  output logic [8*MaxBytes-1:0]         rxCrcCapture
);

  localparam int unsigned LenW = $clog2(MaxBytes + 1);

  crc_ctl_t        ctl;
  logic [LenW-1:0] lenQ;
  logic [LenW-1:0] lenNext;
  logic            crcOutEn;
  logic            cmpFail;

  crc_ctrl #(.MaxBytes(MaxBytes)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startStb   (startStb),
    .bitValid   (bitValid),
    .bitPhase   (bitPhase),
    .cfgRxMode  (cfgRxMode),
    .cfgLen     (cfgLen),
    .cfgSkipAddr(cfgSkipAddr),
    .cmpFail    (cmpFail),
    .ctl        (ctl),
    .lenQ       (lenQ),
    .lenNext    (lenNext),
    .crcOutEn   (crcOutEn),
    .okPulse    (crcOkPulse),
    .errPulse   (crcErrPulse),
    .statusQ    (crcStatus)
  );

  crc_datapath #(.MaxBytes(MaxBytes)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .cfgPoly  (cfgPoly),
    .cfgInit  (cfgInit),
    .lenQ     (lenQ),
    .lenNext  (lenNext),
    .crcOutEn (crcOutEn),
    .dataIn   (dataIn),
    .crcBitOut(crcBitOut),
    .cmpFail  (cmpFail),
    .rxCapture(rxCrcCapture)
  );

endmodule

// File: tb/test_crc_serial_unit.sv
module test_crc_serial_unit;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] cfgPoly = '0;
  logic [23:0] cfgInit = '0;
  logic [1:0]  cfgLen = '0;
  logic        cfgSkipAddr = 1'b0;
  logic        cfgRxMode = 1'b0;
  logic        startStb = 1'b0;
  logic        bitValid = 1'b0;
  logic [1:0]  bitPhase = 2'd3;
  logic        dataIn = 1'b0;
  logic        crcBitOut;
  logic        crcOkPulse;
  logic        crcErrPulse;
  logic        crcStatus;
  logic [23:0] rxCrcCapture;

  int nChecks = 0;
  int nFail = 0;
  logic        expStatus = 1'b0;
  logic [23:0] expCapt = '0;

  // next-packet settings used when a start overlaps the last CRC bit
  int          ovLen = 0;
  logic [23:0] ovPoly = '0;
  logic [23:0] ovInit = '0;
  logic        ovSkip = 1'b0;
  logic        ovRx = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  crc_serial_unit i_crc_serial_unit (
    .clk(clk), .rstN(rstN), .cfgPoly(cfgPoly), .cfgInit(cfgInit), .cfgLen(cfgLen),
    .cfgSkipAddr(cfgSkipAddr), .cfgRxMode(cfgRxMode), .startStb(startStb),
    .bitValid(bitValid), .bitPhase(bitPhase), .dataIn(dataIn), .crcBitOut(crcBitOut),
    .crcOkPulse(crcOkPulse), .crcErrPulse(crcErrPulse), .crcStatus(crcStatus),
    .rxCrcCapture(rxCrcCapture)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] refStep(input logic [23:0] c, input logic [23:0] p, input int w, input logic d);
    logic fb;
    logic [23:0] m;
    m  = 24'((25'd1 << w) - 25'd1);
    fb = c[w-1] ^ d;
    c  = (c << 1) ^ (fb ? (p | 24'd1) : 24'd0);
    return c & m;
  endfunction

  task automatic scramble();
    cfgLen      = 2'($urandom);
    cfgPoly     = 24'($urandom);
    cfgInit     = 24'($urandom);
    cfgSkipAddr = 1'($urandom);
    cfgRxMode   = 1'($urandom);
  endtask

  // assumes the caller stands at a falling edge; returns at the next one
  task automatic sendBit(input logic [1:0] ph, input logic d, output logic o);
    bitValid = 1'b1;
    bitPhase = ph;
    dataIn   = d;
    #1 o = crcBitOut;
    @(negedge clk);
  endtask

  task automatic runPacket(input bit rx, input int len, input logic [23:0] poly, input logic [23:0] init,
                           input bit skip, input int nA, input int nB, input bit corrupt,
                           input bit doStart, input bit overlap);
    int          w;
    logic [23:0] m, exp, sent, got;
    logic [63:0] ab;
    logic [127:0] bb;
    logic        o;
    w   = 8 * len;
    m   = 24'((25'd1 << w) - 25'd1);
    ab  = {$urandom, $urandom};
    bb  = {$urandom, $urandom, $urandom, $urandom};
    exp = init & m;
    got = '0;
    if (doStart) begin
      cfgLen = 2'(len); cfgPoly = poly; cfgInit = init; cfgSkipAddr = skip; cfgRxMode = rx;
      startStb = 1'b1;
      bitValid = 1'($urandom);   // R11: stray body bit beside start is dropped
      bitPhase = 2'd1;
      dataIn   = 1'($urandom);
      @(negedge clk);
      startStb = 1'b0;
    end
    scramble();                  // R10: later changes must not matter
    for (int i = 0; i < nA; i++) begin
      sendBit(2'd0, ab[i], o);
      if (!skip && len != 0) exp = refStep(exp, poly, w, ab[i]);
    end
    for (int i = 0; i < nB; i++) begin
      sendBit(2'd1, bb[i], o);
      if (len != 0) exp = refStep(exp, poly, w, bb[i]);
    end
    if (len == 0) begin
      for (int i = 0; i < 4; i++) begin
        sendBit(2'd2, 1'($urandom), o);
        check("R1", "disabled serial out", 32'(o), 32'd0);
      end
      bitValid = 1'b0; bitPhase = 2'd3;
      check("R1", "disabled pulses", {30'd0, crcOkPulse, crcErrPulse}, 32'd0);
      check("R1", "disabled status", 32'(crcStatus), 32'(expStatus));
      check("R1", "disabled capture", 32'(rxCrcCapture), 32'(expCapt));
      return;
    end
    sent = (corrupt && rx) ? (exp ^ (24'd1 << ($urandom % w))) : exp;
    for (int i = w - 1; i >= 0; i--) begin
      if (overlap && i == 0) begin
        startStb = 1'b1;
        cfgLen = 2'(ovLen); cfgPoly = ovPoly; cfgInit = ovInit; cfgSkipAddr = ovSkip; cfgRxMode = ovRx;
      end
      sendBit(2'd2, rx ? sent[i] : 1'($urandom), o);
      got[i] = o;
      startStb = 1'b0;
    end
    bitValid = 1'b0; bitPhase = 2'd3;
    if (rx) begin
      expStatus = !(corrupt);
      expCapt   = sent & m;
      check(overlap ? "R11 R7" : "R7", "ok pulse", 32'(crcOkPulse), 32'(!corrupt));
      check(overlap ? "R11 R7" : "R7", "err pulse", 32'(crcErrPulse), 32'(corrupt));
      check("R8", "status", 32'(crcStatus), 32'(expStatus));
      check(overlap ? "R11 R9" : "R9", "capture", 32'(rxCrcCapture), 32'(expCapt));
    end else begin
      check("R4 R6", "transmitted CRC", 32'(got & m), 32'(exp));
      check("R7", "no pulse in transmit", {30'd0, crcOkPulse, crcErrPulse}, 32'd0);
      check("R8", "status held", 32'(crcStatus), 32'(expStatus));
    end
    if (!overlap) begin
      sendBit(2'd2, 1'($urandom), o);
      check("R12", "out after done", 32'(o), 32'd0);
      check("R7", "single cycle pulse", {30'd0, crcOkPulse, crcErrPulse}, 32'd0);
      sendBit(2'd2, 1'($urandom), o);
      bitValid = 1'b0; bitPhase = 2'd3;
      check("R12", "no late pulse", {30'd0, crcOkPulse, crcErrPulse}, 32'd0);
      check("R12", "capture after extra bits", 32'(rxCrcCapture), 32'(expCapt));
    end
  endtask

  initial begin
    #(ClkPeriod * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C4C));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8", "reset status", 32'(crcStatus), 32'd0);
    check("R9", "reset capture", 32'(rxCrcCapture), 32'd0);
    check("R7", "reset pulses", {30'd0, crcOkPulse, crcErrPulse}, 32'd0);
    check("R6", "reset serial out", 32'(crcBitOut), 32'd0);

    // R3: empty packet sends the truncated init value
    runPacket(1'b0, 1, 24'h000107, 24'hABCDEF, 1'b0, 0, 0, 1'b0, 1'b1, 1'b0);
    // R2: polynomial with bit 0 clear behaves as if set
    runPacket(1'b0, 1, 24'h00018C, 24'h0000FF, 1'b0, 16, 16, 1'b0, 1'b1, 1'b0);
    // R5: skipped address with no body leaves init
    runPacket(1'b0, 2, 24'h011021, 24'h00FFFF, 1'b1, 32, 0, 1'b0, 1'b1, 1'b0);
    // R7 R9: receive pass and fail
    runPacket(1'b1, 3, 24'h00065B, 24'h555555, 1'b0, 32, 64, 1'b0, 1'b1, 1'b0);
    runPacket(1'b1, 2, 24'h011021, 24'h00FFFF, 1'b0, 24, 40, 1'b1, 1'b1, 1'b0);
    // R8: transmit packet keeps the failing status
    runPacket(1'b0, 3, 24'h00065B, 24'h123456, 1'b1, 16, 16, 1'b0, 1'b1, 1'b0);
    // R1: disabled check
    runPacket(1'b1, 0, 24'h000107, 24'h0000AA, 1'b0, 8, 8, 1'b0, 1'b1, 1'b0);
    // R11: start coincides with the final received CRC bit
    ovLen = 3; ovPoly = 24'h00065B; ovInit = 24'hA5A5A5; ovSkip = 1'b0; ovRx = 1'b1;
    runPacket(1'b1, 2, 24'h011021, 24'h001D0F, 1'b0, 16, 24, 1'b0, 1'b1, 1'b1);
    runPacket(1'b1, 3, 24'h00065B, 24'hA5A5A5, 1'b0, 16, 24, 1'b1, 1'b0, 1'b0);
    ovLen = 1; ovPoly = 24'h000107; ovInit = 24'h000000; ovSkip = 1'b1; ovRx = 1'b0;
    runPacket(1'b1, 1, 24'h000131, 24'h0000FF, 1'b0, 8, 8, 1'b1, 1'b1, 1'b1);
    runPacket(1'b0, 1, 24'h000107, 24'h000000, 1'b1, 8, 20, 1'b0, 1'b0, 1'b0);

    // constrained random packets: R4 R5 R6 R7 R9 R10
    for (int k = 0; k < 40; k++) begin
      int len;
      len = (($urandom % 8) == 0) ? 0 : 1 + int'($urandom % 3);
      runPacket(1'($urandom), len, 24'($urandom), 24'($urandom), 1'($urandom),
                8 + int'($urandom % 33), int'($urandom % 100), 1'($urandom), 1'b1, 1'b0);
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule